// File: doc/BRIEF.md
# Self-Synchronizing Serial Descrambler

This block undoes the bit whitening that a transmitter applies before modulation. It works on one bit at a time. It keeps a seven-stage history of the scrambled bits it has received. Each output bit is the incoming bit exclusive-ored with two stages of that history, at delays of four and seven bits (generator x^7 + x^4 + 1). The history is loaded with received bits and not with its own results. Because of this, the block needs no seed. After seven valid bits its output is correct whatever the history held before.

A mode input turns the same datapath into the matching scrambler by feeding the history with the output bit instead. A scrambler in one instance followed by a descrambler in another returns the original data, which makes the block usable for loopback testing. A synchronous clear empties the history at a frame boundary. Framing itself is decided outside the block.

Top module: `selfsync_descrambler`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_vld_o` is 0 and `out_dat_o` is 0. Reset also empties the history, so a run of zero input bits then gives zero output bits.
- R2: `out_vld_o` equals the previous cycle's `in_vld_i` whenever `rst` and `clr_i` were low in that cycle. `out_dat_o` changes only on the cycle after an accepted input bit, and otherwise keeps its value.
- R3: With `scr_mode_i` = 0 (descramble), the accepted bit x[n] gives the output y[n] = x[n] xor x[n-4] xor x[n-7]. Here x[k] is the k-th accepted input bit, and bits from before the last clear or reset count as 0.
- R4: Cycles with `in_vld_i` = 0 leave the history untouched. Idle gaps of any length between bits do not change any later output bit.
- R5: In descramble mode, whatever the history holds, every output bit from the eighth accepted bit onward matches the R3 formula computed on the accepted bits alone.
- R6: In descramble mode, flipping one scrambled input bit at position n corrupts exactly three output bits, at positions n, n+4 and n+7.
- R7: In descramble mode, flipping two input bits at positions n and n+3 corrupts exactly four output bits, at n, n+3, n+4 and n+10, because the two errors cancel at n+7.
- R8: With `scr_mode_i` = 1 (scramble), y[n] = x[n] xor y[n-4] xor y[n-7]. Scrambling a stream and then descrambling it, each pass starting from a clear, returns the original stream bit for bit.
- R9: A high `clr_i` zeroes the history, gives `out_vld_o` = 0 on the next cycle and keeps `out_dat_o`. It takes priority over `in_vld_i`, so the bit presented in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of the bit history |
| scr_mode_i | input | 1 | 0 = descramble, 1 = scramble |
| in_vld_i | input | 1 | Input bit valid |
| in_dat_i | input | 1 | Serial input bit |
| out_vld_o | output | 1 | Output bit valid, one cycle after input |
| out_dat_o | output | 1 | Serial output bit |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- that the history holds still on idle cycles;
- that a clear empties the history and drops the valid;
- which bit enters the history in each mode: the received bit when descrambling, the produced bit when scrambling.

Other properties only appear over many bits, so the bench scenarios have to show them:
- the seven-bit self-synchronisation from an arbitrary history;
- the three-bit error spread of a single corrupted input;
- the cancellation of two errors three bits apart;
- the scramble-then-descramble round trip.

// File: rtl/desc_pkg.sv
package desc_pkg;

    localparam int HIST_LEN  = 7;
    localparam int TAP_NEAR  = 4;
    localparam int TAP_FAR   = 7;

    typedef enum logic {
        MODE_DESCRAMBLE = 1'b0,
        MODE_SCRAMBLE   = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic vld;
        logic dat;
    } beat_t;

    function automatic logic tap_sum(input logic [HIST_LEN-1:0] hist,
                                     input int near_pos,
                                     input int far_pos);
        return hist[near_pos-1] ^ hist[far_pos-1];
    endfunction

endpackage

// File: rtl/desc_history.sv
module desc_history
    import desc_pkg::*;
#(
    parameter int LEN = HIST_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           shift_en,
    input  logic           feed_bit,
    output logic [LEN-1:0] hist
);

    localparam logic [LEN-1:0] EMPTY = '0;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= EMPTY;
        end else if (shift_en) begin
            hist <= {hist[LEN-2:0], feed_bit};
        end
    end

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clr) |=> $stable(hist));

    p_clear_empty_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hist == EMPTY));

endmodule

// File: rtl/desc_mixer.sv
module desc_mixer
    import desc_pkg::*;
#(
    parameter int LEN  = HIST_LEN,
    parameter int NEAR = TAP_NEAR,
    parameter int FAR  = TAP_FAR
) (
    input  logic           in_bit,
    input  op_mode_e       mode,
    input  logic [LEN-1:0] hist,
    output logic           out_bit,
    output logic           feed_bit
);

    logic taps;

    generate
        if (NEAR == FAR) begin : g_single_tap
            assign taps = 1'b0;
        end else begin : g_two_taps
            assign taps = tap_sum(hist, NEAR, FAR);
        end
    endgenerate

    always_comb begin
        out_bit = in_bit ^ taps;
        unique case (mode)
            MODE_SCRAMBLE:   feed_bit = out_bit;
            default:         feed_bit = in_bit;
        endcase
    end

endmodule

// File: rtl/desc_outreg.sv
module desc_outreg
    import desc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  beat_t nxt,
    output beat_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (clr) begin
            cur.vld <= 1'b0;
        end else begin
            cur.vld <= nxt.vld;
            if (nxt.vld) begin
                cur.dat <= nxt.dat;
            end
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cur.vld == $past(nxt.vld)));

    p_hold_dat_r2: assert property (@(posedge clk) disable iff (rst)
        (!nxt.vld || clr) |=> $stable(cur.dat));

    p_clear_drop_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !cur.vld);

endmodule

// File: rtl/selfsync_descrambler.sv
module selfsync_descrambler
    import desc_pkg::*;
#(
    parameter int LEN  = HIST_LEN,
    parameter int NEAR = TAP_NEAR,
    parameter int FAR  = TAP_FAR
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic scr_mode_i,
    input  logic in_vld_i,
    input  logic in_dat_i,
    output logic out_vld_o,
    output logic out_dat_o
);

    logic [LEN-1:0] hist;
    logic           mix_bit;
    logic           feed_bit;
    op_mode_e       mode;
    beat_t          nxt_beat;
    beat_t          cur_beat;

    assign mode = op_mode_e'(scr_mode_i);

    desc_mixer #(.LEN(LEN), .NEAR(NEAR), .FAR(FAR)) u_mix (
        .in_bit  (in_dat_i),
        .mode    (mode),
        .hist    (hist),
        .out_bit (mix_bit),
        .feed_bit(feed_bit)
    );

    desc_history #(.LEN(LEN)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_i),
        .shift_en(in_vld_i),
        .feed_bit(feed_bit),
        .hist    (hist)
    );

    assign nxt_beat.vld = in_vld_i;
    assign nxt_beat.dat = mix_bit;

    desc_outreg u_out (
        .clk(clk),
        .rst(rst),
        .clr(clr_i),
        .nxt(nxt_beat),
        .cur(cur_beat)
    );

    assign out_vld_o = cur_beat.vld;
    assign out_dat_o = cur_beat.dat;

    p_feed_rx_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && !clr_i && mode == MODE_DESCRAMBLE) |=> (hist[0] == $past(in_dat_i)));

    p_feed_tx_r8: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && !clr_i && mode == MODE_SCRAMBLE) |=> (hist[0] == out_dat_o));

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_vld_o && !out_dat_o));

endmodule

// File: tb/selfsync_descrambler_tb.sv
module selfsync_descrambler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_i = 1'b0;
    logic scr_mode_i = 1'b0;
    logic in_vld_i = 1'b0;
    logic in_dat_i = 1'b0;
    logic out_vld_o;
    logic out_dat_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int past[$];
    int exp_vld = 0;
    int exp_dat = 0;
    int skip_cnt = 0;

    int plain [NBITS];
    int scr   [NBITS];
    int got   [NBITS];

    always #(CLK_PERIOD/2) clk = ~clk;

    selfsync_descrambler dut_i (
        .clk(clk), .rst(rst), .clr_i(clr_i), .scr_mode_i(scr_mode_i),
        .in_vld_i(in_vld_i), .in_dat_i(in_dat_i),
        .out_vld_o(out_vld_o), .out_dat_o(out_dat_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        past.delete();
        for (int i = 0; i < 7; i++) past.push_back(0);
    endtask

    task automatic step(input int v, input int d, input string tag);
        int y;
        in_vld_i = v[0];
        in_dat_i = d[0];
        @(posedge clk);
        #1;
        if (v != 0) begin
            y = d ^ past[3] ^ past[6];
            past.push_front(scr_mode_i ? y : d);
            void'(past.pop_back());
            exp_dat = y;
            exp_vld = 1;
        end else begin
            exp_vld = 0;
        end
        check({tag, " vld"}, int'(out_vld_o), exp_vld);
        if (skip_cnt > 0) begin
            if (v != 0) skip_cnt--;
        end else begin
            check({tag, " dat"}, int'(out_dat_o), exp_dat);
        end
    endtask

    task automatic do_clear();
        clr_i = 1'b1;
        in_vld_i = 1'b1;
        in_dat_i = 1'b1;
        @(posedge clk);
        #1;
        check("R9 clear drops valid", int'(out_vld_o), 0);
        check("R9 clear keeps data", int'(out_dat_o), exp_dat);
        exp_vld = 0;
        model_clear();
        clr_i = 1'b0;
        in_vld_i = 1'b0;
    endtask

    function automatic void make_scrambled();
        int q[$];
        int y;
        for (int i = 0; i < 7; i++) q.push_back(0);
        for (int i = 0; i < NBITS; i++) begin
            y = plain[i] ^ q[3] ^ q[6];
            scr[i] = y;
            q.push_front(y);
            void'(q.pop_back());
        end
    endfunction

    task automatic run_errors(input int e1, input int e2, input string tag,
                              input int exp_cnt, input int p0, input int p1,
                              input int p2, input int p3);
        int cnt;
        scr_mode_i = 1'b0;
        do_clear();
        for (int i = 0; i < NBITS; i++) begin
            int b;
            b = scr[i];
            if (i == e1 || i == e2) b = b ^ 1;
            step(1, b, tag);
            got[i] = int'(out_dat_o);
        end
        cnt = 0;
        for (int i = 0; i < NBITS; i++) begin
            if (got[i] != plain[i]) begin
                cnt++;
                if (!(i == p0 || i == p1 || i == p2 || i == p3))
                    check({tag, " error position"}, i, p0);
            end
        end
        check({tag, " error count"}, cnt, exp_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset vld", int'(out_vld_o), 0);
        check("R1 reset dat", int'(out_dat_o), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 first cycle vld", int'(out_vld_o), 0);

        // R1: zero input after reset gives zero output
        for (int i = 0; i < 10; i++) step(1, 0, "R1 zero stream");

        // R3: single one shows the impulse response at 0, 4 and 7
        step(1, 1, "R3 impulse");
        for (int i = 0; i < 9; i++) step(1, 0, "R3 impulse tail");

        // R3 and R2: random stream, continuous valid
        for (int i = 0; i < 60; i++) step(1, int'($urandom_range(1)), "R3 random");

        // R4 and R2: gaps between bits
        for (int i = 0; i < 60; i++) begin
            step(1, int'($urandom_range(1)), "R4 gapped");
            repeat ($urandom_range(3)) step(0, int'($urandom_range(1)), "R4 idle");
        end

        // R9: clear mid-stream, then check output restarts from empty history
        do_clear();
        for (int i = 0; i < 12; i++) step(1, int'($urandom_range(1)), "R9 after clear");

        // R5: arbitrary history, compare only after seven bits
        for (int i = 0; i < 9; i++) step(1, int'($urandom_range(1)), "R5 garbage");
        for (int i = 0; i < 7; i++) past[i] = int'($urandom_range(1));
        skip_cnt = 7;
        for (int i = 0; i < 30; i++) step(1, int'($urandom_range(1)), "R5 resync");

        // R8: scrambler mode against model, then round trip
        scr_mode_i = 1'b1;
        do_clear();
        for (int i = 0; i < NBITS; i++) plain[i] = int'($urandom_range(1));
        for (int i = 0; i < NBITS; i++) begin
            step(1, plain[i], "R8 scramble");
            scr[i] = int'(out_dat_o);
        end
        scr_mode_i = 1'b0;
        do_clear();
        for (int i = 0; i < NBITS; i++) begin
            step(1, scr[i], "R8 descramble");
            check("R8 round trip", int'(out_dat_o), plain[i]);
        end

        // R6 and R7: error spreading and cancelling
        for (int i = 0; i < NBITS; i++) plain[i] = int'($urandom_range(1));
        make_scrambled();
        run_errors(-1, -1, "R6 clean", 0, -1, -1, -1, -1);
        run_errors(20, -1, "R6 single error", 3, 20, 24, 27, -1);
        run_errors(20, 23, "R7 paired error", 4, 20, 23, 24, 30);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule